// File: doc/BRIEF.md
# Watchdog Compare Channel Array

This block holds a small set of 16-bit compare channels that watch a shared free-running timer. The timer is supplied to the block as a high byte and a low byte. Each channel keeps a compare value, which is loaded one byte at a time over a simple write-only register bus. A per-channel comparator enable follows the order of those writes: writing the low byte disarms the channel and writing the high byte arms it. When an armed channel that is set to plain compare mode sees the timer equal its compare value, it emits a one-cycle compare event.

One designated channel can also serve as a system watchdog. While the global watchdog-enable bit is set, a match on that channel produces a one-cycle internal reset request instead of a compare event. That request is meant for internal reset logic only and never reaches an external reset pin. Software keeps the reset from firing by rewriting the compare value, low byte then high byte, so that it stays ahead of the timer. Any capture or PWM selection in the channel mode bits suppresses both the event and the reset.

Top module: `wdc_top`

## Requirements
- R1: A match requires all 16 bits of the compare value to equal {timer_hi_i, timer_lo_i}; a value that differs only in the high byte or only in the low byte produces no output.
- R2: A write to a channel's low-byte register (channel base + 0) loads bits 7:0 of the compare value and disarms that channel, so a later match produces no output.
- R3: A write to a channel's high-byte register (channel base + 1) loads bits 15:8 of the compare value and arms that channel.
- R4: On the watchdog channel (index WDOG_CH, default 4) an armed match raises wdt_rst_o only while bit 0 of the global register (address 0) is 1; in that case cmp_match_o for that channel stays low. While that bit is 0 the same match pulses cmp_match_o[WDOG_CH] and leaves wdt_rst_o low.
- R5: The channel mode register (channel base + 2) has bit 0 = match enable, bit 1 = rising capture, bit 2 = falling capture, bit 3 = PWM; a channel matches only when the value of bits 3:0 is 0b0001, and any other setting suppresses both outputs.
- R6: Output pulses last exactly one cycle and appear in the cycle after the first cycle in which the armed match holds; a match that stays true yields a single pulse.
- R7: Rewriting low then high byte to a value ahead of the timer before the timer reaches the old value prevents the reset; the reset then fires when the timer reaches the new value.
- R8: Reset (rst_ni low) clears all compare values, comparator enables, mode registers and the global watchdog-enable bit, and drives both outputs low.
- R9: Channels other than WDOG_CH never raise wdt_rst_o; their armed matches pulse their own cmp_match_o bit.
- R10: Channel c has its base address at 1 + 4*c; address 0 holds the global register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (5) | Register write address |
| wr_data_i | input | BYTE_W (8) | Register write data |
| timer_lo_i | input | BYTE_W (8) | Shared timer, low byte |
| timer_hi_i | input | BYTE_W (8) | Shared timer, high byte |
| cmp_match_o | output | NUM_CH (5) | Per-channel compare event pulse |
| wdt_rst_o | output | 1 | Internal watchdog reset request pulse |

## Verification
The assertions take for granted that the timer bytes and the write bus change only between clock edges and that a single address is written per cycle, so the comparator enable after a low- or high-byte write follows directly from that one write. They also rely on the global enable and the compare value being stable across the cycle that produced a pulse, which holds because both are registers. The stimulus drives the timer and the bus only on the falling edge, issues one write per cycle, and places the timer on chosen values rather than letting it run freely except in the servicing scenario, where it advances one count per cycle.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

  typedef struct packed {
    logic pwm;
    logic cap_fall;
    logic cap_rise;
    logic match_en;
  } ch_mode_t;

  localparam int MODE_W   = 4;
  localparam int GLB_ADDR = 0;
  localparam int WDOG_BIT = 0;
  localparam int CH_BASE  = 1;
  localparam int CH_STEP  = 4;
  localparam int OFF_LO   = 0;
  localparam int OFF_HI   = 1;
  localparam int OFF_MODE = 2;

  function automatic int ch_addr(input int ch, input int off);
    return CH_BASE + CH_STEP * ch + off;
  endfunction

endpackage

// File: rtl/wdc_regbus.sv
module wdc_regbus
  import wdc_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int ADDR_W = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] lo_we_o,
  output logic [NUM_CH-1:0] hi_we_o,
  output logic [NUM_CH-1:0] mode_we_o,
  output logic              wdog_en_o
);

  logic glb_we;
  logic wdog_en_q;

  assign glb_we = wr_en_i && (wr_addr_i == ADDR_W'(GLB_ADDR));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign lo_we_o[c]   = wr_en_i && (wr_addr_i == ADDR_W'(ch_addr(c, OFF_LO)));
    assign hi_we_o[c]   = wr_en_i && (wr_addr_i == ADDR_W'(ch_addr(c, OFF_HI)));
    assign mode_we_o[c] = wr_en_i && (wr_addr_i == ADDR_W'(ch_addr(c, OFF_MODE)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wdog_en_q <= 1'b0;
    else if (glb_we) wdog_en_q <= wr_data_i[WDOG_BIT];
  end

  assign wdog_en_o = wdog_en_q;

  logic unused_glb_bits;
  assign unused_glb_bits = ^{wr_data_i[BYTE_W-1:WDOG_BIT+1]};

endmodule

// File: rtl/wdc_mode_dec.sv
module wdc_mode_dec
  import wdc_pkg::*;
(
  input  ch_mode_t mode_i,
  output logic     cmp_mode_o
);

  // plain compare only: any capture edge or PWM takes the comparator away
  always_comb begin
    cmp_mode_o = mode_i.match_en;
    if (mode_i.cap_rise || mode_i.cap_fall || mode_i.pwm) cmp_mode_o = 1'b0;
  end

endmodule

// File: rtl/wdc_channel.sv
module wdc_channel
  import wdc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter bit IS_WDOG = 1'b0,
  localparam int TMR_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic              mode_we_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic              wdog_en_i,
  output logic              cmp_ev_o,
  output logic              wdt_req_o,
  output logic              en_o,
  output logic [TMR_W-1:0]  cmp_val_o
);

  logic [BYTE_W-1:0] cmp_lo_q, cmp_hi_q;
  logic              en_q;
  ch_mode_t          mode_q;
  logic              cmp_mode;
  logic              hit, hit_q, hit_rise;
  logic              wd_act;
  logic              ev_q, wdt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      en_q     <= 1'b0;
    end else if (lo_we_i) begin
      cmp_lo_q <= wr_data_i;
      en_q     <= 1'b0;
    end else if (hi_we_i) begin
      cmp_hi_q <= wr_data_i;
      en_q     <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= ch_mode_t'(wr_data_i[MODE_W-1:0]);
  end

  logic unused_mode_bits;
  assign unused_mode_bits = ^{wr_data_i[BYTE_W-1:MODE_W]};

  wdc_mode_dec u_dec (
    .mode_i     (mode_q),
    .cmp_mode_o (cmp_mode)
  );

  assign cmp_val_o = {cmp_hi_q, cmp_lo_q};
  assign hit       = en_q && cmp_mode && (timer_i == cmp_val_o);
  assign hit_rise  = hit && !hit_q;

  if (IS_WDOG) begin : g_wd
    assign wd_act = wdog_en_i;
  end else begin : g_nowd
    logic unused_wd;
    assign unused_wd = wdog_en_i;
    assign wd_act    = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      ev_q  <= 1'b0;
      wdt_q <= 1'b0;
    end else begin
      hit_q <= hit;
      ev_q  <= hit_rise && !wd_act;
      wdt_q <= hit_rise && wd_act;
    end
  end

  assign cmp_ev_o  = ev_q;
  assign wdt_req_o = wdt_q;
  assign en_o      = en_q;

endmodule

// File: rtl/wdc_top.sv
module wdc_top
  import wdc_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int WDOG_CH = 4,
  parameter int ADDR_W  = 5,
  parameter int BYTE_W  = 8,
  localparam int TMR_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] timer_lo_i,
  input  logic [BYTE_W-1:0] timer_hi_i,
  output logic [NUM_CH-1:0] cmp_match_o,
  output logic              wdt_rst_o
);

  logic [NUM_CH-1:0] lo_we, hi_we, mode_we;
  logic [NUM_CH-1:0] wdt_req, ch_en;
  logic [TMR_W-1:0]  cmp_val [NUM_CH];
  logic [TMR_W-1:0]  timer;
  logic              wdog_en;
  logic              wd_ch_en;
  logic [TMR_W-1:0]  wd_ch_cmp;

  assign timer = {timer_hi_i, timer_lo_i};

  wdc_regbus #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lo_we_o   (lo_we),
    .hi_we_o   (hi_we),
    .mode_we_o (mode_we),
    .wdog_en_o (wdog_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wdc_channel #(
      .BYTE_W  (BYTE_W),
      .IS_WDOG (c == WDOG_CH)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lo_we_i   (lo_we[c]),
      .hi_we_i   (hi_we[c]),
      .mode_we_i (mode_we[c]),
      .wr_data_i (wr_data_i),
      .timer_i   (timer),
      .wdog_en_i (wdog_en),
      .cmp_ev_o  (cmp_match_o[c]),
      .wdt_req_o (wdt_req[c]),
      .en_o      (ch_en[c]),
      .cmp_val_o (cmp_val[c])
    );
  end

  // internal reset request only; not routed to any pin driver
  assign wdt_rst_o = |wdt_req;
  assign wd_ch_en  = ch_en[WDOG_CH];
  assign wd_ch_cmp = cmp_val[WDOG_CH];

endmodule

// File: rtl/wdc_checker.sv
module wdc_checker
  import wdc_pkg::*;
#(
  parameter int NUM_CH  = 5,
  parameter int WDOG_CH = 4,
  parameter int ADDR_W  = 5,
  parameter int TMR_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [TMR_W-1:0]  timer,
  input logic [NUM_CH-1:0] cmp_match_o,
  input logic              wdt_rst_o,
  input logic              wdog_en,
  input logic              wd_ch_en,
  input logic [TMR_W-1:0]  wd_ch_cmp
);

  localparam logic [ADDR_W-1:0] WD_LO = ADDR_W'(ch_addr(WDOG_CH, OFF_LO));
  localparam logic [ADDR_W-1:0] WD_HI = ADDR_W'(ch_addr(WDOG_CH, OFF_HI));

  AST_LO_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == WD_LO) |=> !wd_ch_en); // R2
  AST_HI_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == WD_HI) |=> wd_ch_en); // R3
  AST_FULL_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(timer == wd_ch_cmp)); // R1
  AST_NEEDS_WDOG_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(wdog_en)); // R4
  AST_NO_EVENT_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> !cmp_match_o[WDOG_CH]); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R6
  AST_EVENT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_match_o[0] |=> !cmp_match_o[0]); // R6

endmodule

bind wdc_top wdc_checker #(
  .NUM_CH  (NUM_CH),
  .WDOG_CH (WDOG_CH),
  .ADDR_W  (ADDR_W),
  .TMR_W   (TMR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .timer       (timer),
  .cmp_match_o (cmp_match_o),
  .wdt_rst_o   (wdt_rst_o),
  .wdog_en     (wdog_en),
  .wd_ch_en    (wd_ch_en),
  .wd_ch_cmp   (wd_ch_cmp)
);

// File: tb/tb_wdc_top.sv
module tb_wdc_top;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 5;
  localparam int WD     = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] tmr = '0;
  logic [NUM_CH-1:0] cmp_match;
  logic        wdt_rst;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdc_top dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .timer_lo_i  (tmr[7:0]),
    .timer_hi_i  (tmr[15:8]),
    .cmp_match_o (cmp_match),
    .wdt_rst_o   (wdt_rst)
  );

  function automatic logic [4:0] a_ch(int ch, int off);
    return 5'(1 + 4*ch + off);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic step(logic [15:0] t);
    tmr = t;
    tick();
  endtask

  task automatic load_cmp(int ch, logic [15:0] v);
    wr(a_ch(ch, 0), v[7:0]);
    wr(a_ch(ch, 1), v[15:8]);
  endtask

  task automatic t_reset();
    chk("R8 wdt after reset", 32'(wdt_rst), 0);
    chk("R8 events after reset", 32'(cmp_match), 0);
  endtask

  task automatic t_arm_match();
    wr(5'd0, 8'h01);
    wr(a_ch(WD, 2), 8'h01);
    tmr = 16'h0000;
    load_cmp(WD, 16'h1234);
    step(16'h1233);
    chk("R3 no reset before match", 32'(wdt_rst), 0);
    step(16'h1234);
    chk("R3 R10 reset on match", 32'(wdt_rst), 1);
    chk("R4 no event while watchdog", 32'(cmp_match[WD]), 0);
    step(16'h1234);
    chk("R6 single pulse on held match", 32'(wdt_rst), 0);
  endtask

  task automatic t_full_width();
    step(16'h1334);
    chk("R1 high byte differs", 32'(wdt_rst), 0);
    step(16'h0034);
    chk("R1 high byte differs 2", 32'(wdt_rst), 0);
    step(16'h1235);
    chk("R1 low byte differs", 32'(wdt_rst), 0);
    step(16'h1234);
    chk("R1 full match fires again", 32'(wdt_rst), 1);
  endtask

  task automatic t_lo_disarms();
    step(16'h0000);
    wr(a_ch(WD, 0), 8'h34);
    step(16'h1234);
    chk("R2 low write disarms", 32'(wdt_rst), 0);
    step(16'h1234);
    chk("R2 still disarmed", 32'(wdt_rst), 0);
  endtask

  task automatic t_wdog_off();
    step(16'h0000);
    wr(5'd0, 8'h00);
    wr(a_ch(WD, 1), 8'h12);
    step(16'h1234);
    chk("R4 no reset with watchdog off", 32'(wdt_rst), 0);
    chk("R4 ordinary event with watchdog off", 32'(cmp_match[WD]), 1);
    step(16'h0000);
    wr(5'd0, 8'h01);
  endtask

  task automatic t_modes();
    logic [7:0] bad [3] = '{8'h09, 8'h03, 8'h05};
    for (int i = 0; i < 3; i++) begin
      wr(a_ch(WD, 2), bad[i]);
      step(16'h0000);
      step(16'h1234);
      chk("R5 mode suppresses reset", 32'(wdt_rst), 0);
      chk("R5 mode suppresses event", 32'(cmp_match[WD]), 0);
    end
    wr(a_ch(WD, 2), 8'h00);
    step(16'h0000);
    step(16'h1234);
    chk("R5 match enable off", 32'(wdt_rst), 0);
    wr(a_ch(WD, 2), 8'h01);
  endtask

  task automatic t_service();
    int fired = 0;
    int fired_at = -1;
    step(16'h0000);
    load_cmp(WD, 16'h0100);
    for (int i = 0; i < 16'h0180; i++) begin
      tmr = 16'h00F0 + 16'(i);
      wr_en = 1'b0;
      if (i == 8)  begin wr_en = 1'b1; wr_addr = a_ch(WD, 0); wr_data = 8'h00; end
      if (i == 9)  begin wr_en = 1'b1; wr_addr = a_ch(WD, 1); wr_data = 8'h02; end
      tick();
      wr_en = 1'b0;
      if (wdt_rst) begin fired++; fired_at = int'(tmr); end
    end
    chk("R7 serviced reset count", 32'(fired), 1);
    chk("R7 reset at new value", 32'(fired_at), 32'h0200);
  endtask

  task automatic t_other_ch();
    step(16'h0000);
    wr(a_ch(0, 2), 8'h01);
    load_cmp(0, 16'h5555);
    step(16'h5555);
    chk("R9 channel 0 event", 32'(cmp_match[0]), 1);
    chk("R9 channel 0 no reset", 32'(wdt_rst), 0);
    step(16'h5555);
    chk("R9 R6 channel 0 single event", 32'(cmp_match[0]), 0);
  endtask

  task automatic t_reset_mid();
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    wr(5'd0, 8'h01);
    wr(a_ch(WD, 2), 8'h01);
    step(16'h0001);
    step(16'h0000);
    chk("R8 enable cleared by reset", 32'(wdt_rst), 0);
    wr(a_ch(WD, 1), 8'h00);
    step(16'h0001);
    step(16'h0000);
    chk("R8 compare cleared to zero", 32'(wdt_rst), 1);
    step(16'h5555);
    chk("R8 channel 0 mode cleared", 32'(cmp_match[0]), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_arm_match();
    t_full_width();
    t_lo_disarms();
    t_wdog_off();
    t_modes();
    t_service();
    t_other_ch();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule